// File: doc/BRIEF.md
# Fine-grain pipelined unsigned array multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It is pipelined so finely that every register bit is fed by a logic function of no more than four bits from the register stage before it. A new operand pair can be presented on every clock cycle, and results stream out in the same order after a fixed delay of 2N-1 cycles. A flag travels next to the data and marks which output cycles hold real products.

No stage ripples a carry across its own bit positions. The partial-product rows are accumulated in carry-save form, and each carry is registered and folded into the next row. After the last row of partial products has been added, a tail of half-adder stages clears the pending carries. Each tail stage starts one bit position higher than the one before it. The operand bits and the low result bits that are already final are moved forward through plain delay registers, so every bit of a product reaches the output on the same edge.

Top module: `lut_pipe_mult`

## Requirements
- R1: While out_valid is high, p equals the unsigned 2N-bit product a*b of the operand pair sampled on the rising edge 2N-2 edges earlier. This is a latency of 2N-1 register stages.
- R2: out_valid is high right after edge e exactly when in_valid was high at edge e-(2N-2) and rst_n was high at every edge from then up to e. While in_valid is low, no valid result is produced.
- R3: A new operand pair is accepted on every cycle with no stall. Pairs presented back to back give their own correct products in input order, with no interference between them.
- R4: Inside the pipeline, the top bit position (2N-1) never holds a set sum bit and a set carry bit at the same time, so no carry is lost. The largest operands (all ones times all ones) give the exact product 2^(2N) - 2^(N+1) + 1.
- R5: The reset is synchronous and active low, and it clears only the valid line. out_valid is low while rst_n is low and for the 2N-2 edges after it is released. Pairs that were in flight when reset was applied are never flagged valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register samples on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the valid line |
| in_valid | input | 1 | Marks the operand pair on a and b as a real request |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| out_valid | output | 1 | High when p carries the product of a flagged pair |
| p | output | 2N | Unsigned product |

## Verification
Directed corner pairs come first. Zero and one operands expose a stuck or swapped partial-product bit. Alternating 0xAA/0x55 patterns tell a carry moved to the wrong weight apart from a dropped one. All-ones operands load every carry-save column and drive carries into the top position, which only the full tail of resolution stages can clear. Long back-to-back random streams then show that neighbouring pairs do not leak into each other. Random gaps in in_valid, and a reset asserted in mid-stream, show that the flag tracks its own data and that requests caught in flight by a reset are discarded.

// File: rtl/lut_mult_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the fine-grain pipelined multiplier.
// Assumes operand widths of at least 4 bits.
package lut_mult_pkg;

    // Number of register stages between the operands and the product.
    function automatic int pipe_depth(input int width);
        return 2 * width - 1;
    endfunction

endpackage

// File: rtl/mult_seed_row.sv
`timescale 1ns/1ps
// Module: first pipeline stage. It adds partial-product rows 0 and 1 of the
// array. No earlier partial sum exists, so each column cell adds two single
// AND products (four inputs). The column carries are registered rather than
// rippled. Assumes N >= 4. Data registers have no reset.
module mult_seed_row #(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic [N-1:0]     a_i,
    input  logic [1:0]       b_lo_i,
    output logic [2*N-1:0]   sum_o,
    output logic [2*N-1:0]   carry_o
);
    localparam int W = 2 * N;

    logic [W-1:0] sum_d;
    logic [W-1:0] cgen;

    generate
        for (genvar w = 0; w < W; w++) begin : g_col
            if (w == 0) begin : g_lsb
                assign sum_d[w] = a_i[0] & b_lo_i[0];
                assign cgen[w]  = 1'b0;
            end else if (w < N) begin : g_pair
                logic pp_r0;
                logic pp_r1;
                assign pp_r0    = a_i[w] & b_lo_i[0];
                assign pp_r1    = a_i[w-1] & b_lo_i[1];
                assign sum_d[w] = pp_r0 ^ pp_r1;
                assign cgen[w]  = pp_r0 & pp_r1;
            end else if (w == N) begin : g_top
                assign sum_d[w] = a_i[N-1] & b_lo_i[1];
                assign cgen[w]  = 1'b0;
            end else begin : g_empty
                assign sum_d[w] = 1'b0;
                assign cgen[w]  = 1'b0;
            end
        end
    endgenerate

    // Capture the column sums and the carries, moved up one weight.
    always_ff @(posedge clk) begin
        sum_o   <= sum_d;
        carry_o <= cgen << 1;
    end

endmodule

// File: rtl/mult_fold_row.sv
`timescale 1ns/1ps
// Module: accumulation stage K (2..N-1). It folds partial-product row K into
// the carry-save pair. Each active column is a full adder over one AND
// product, the incoming sum bit and the incoming carry bit (four inputs).
// Columns outside the row pass forward. Their carry bit is known to be zero,
// so sum|carry is exact there. Assumes 2 <= K <= N-1.
module mult_fold_row #(
    parameter int N = 8,
    parameter int K = 2
) (
    input  logic             clk,
    input  logic [N-1:0]     a_i,
    input  logic             b_bit_i,
    input  logic [2*N-1:0]   sum_i,
    input  logic [2*N-1:0]   carry_i,
    output logic [2*N-1:0]   sum_o,
    output logic [2*N-1:0]   carry_o
);
    localparam int W = 2 * N;

    logic [W-1:0] sum_d;
    logic [W-1:0] cgen;

    generate
        for (genvar w = 0; w < W; w++) begin : g_col
            if (w >= K && w < K + N) begin : g_fa
                logic pp;
                assign pp       = a_i[w-K] & b_bit_i;
                assign sum_d[w] = pp ^ sum_i[w] ^ carry_i[w];
                assign cgen[w]  = (pp & sum_i[w]) | (pp & carry_i[w]) | (sum_i[w] & carry_i[w]);
            end else begin : g_pass
                assign sum_d[w] = sum_i[w] | carry_i[w];
                assign cgen[w]  = 1'b0;
            end
        end
    endgenerate

    // Register the new carry-save pair; carries advance one weight.
    always_ff @(posedge clk) begin
        sum_o   <= sum_d;
        carry_o <= cgen << 1;
    end

endmodule

// File: rtl/mult_resolve_row.sv
`timescale 1ns/1ps
// Module: carry resolution stage T (1..N-1) of the tail. Pending carries can
// only sit at weights N+T-1 and above. Those columns get a half adder. The top
// column keeps only the XOR, since the product never overflows 2N bits.
// Lower columns are final and pass forward. Assumes 1 <= T <= N-1.
module mult_resolve_row #(
    parameter int N = 8,
    parameter int T = 1
) (
    input  logic             clk,
    input  logic [2*N-1:0]   sum_i,
    input  logic [2*N-1:0]   carry_i,
    output logic [2*N-1:0]   sum_o,
    output logic [2*N-1:0]   carry_o
);
    localparam int W  = 2 * N;
    localparam int LO = N + T - 1;

    logic [W-1:0] sum_d;
    logic [W-1:0] cgen;

    generate
        for (genvar w = 0; w < W; w++) begin : g_col
            if (w >= LO && w < W - 1) begin : g_ha
                assign sum_d[w] = sum_i[w] ^ carry_i[w];
                assign cgen[w]  = sum_i[w] & carry_i[w];
            end else if (w == W - 1) begin : g_msb
                assign sum_d[w] = sum_i[w] ^ carry_i[w];
                assign cgen[w]  = 1'b0;
            end else begin : g_pass
                assign sum_d[w] = sum_i[w] | carry_i[w];
                assign cgen[w]  = 1'b0;
            end
        end
    endgenerate

    // Register the partially resolved pair; carries advance one weight.
    always_ff @(posedge clk) begin
        sum_o   <= sum_d;
        carry_o <= cgen << 1;
    end

endmodule

// File: rtl/mult_valid_line.sv
`timescale 1ns/1ps
// Module: shift line that carries the request flag next to the data pipe.
// The synchronous active-low reset empties the whole line. Assumes DEPTH >= 2.
module mult_valid_line #(
    parameter int DEPTH = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    output logic flag_o
);
    logic [DEPTH-1:0] line_q;

    // Shift the flag one step per clock, or clear the line on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= {line_q[DEPTH-2:0], flag_i};
        end
    end

    assign flag_o = line_q[DEPTH-1];

endmodule

// File: rtl/lut_pipe_mult.sv
`timescale 1ns/1ps
// Module: top of the fine-grain pipelined unsigned N x N multiplier.
// Stage 1 adds rows 0 and 1. Stages 2..N-1 fold in one row each. Stages
// N..2N-2 resolve carries. Stage 2N-1 clears the last carry at the top bit
// and drives p. Operand bits are delayed so that each row meets its sum.
// Only the valid line is reset. Assumes 4 <= N <= 64.
module lut_pipe_mult #(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [N-1:0]     a,
    input  logic [N-1:0]     b,
    output logic             out_valid,
    output logic [2*N-1:0]   p
);
    import lut_mult_pkg::*;

    localparam int W   = 2 * N;
    localparam int LAT = pipe_depth(N);

    logic [LAT-1:1][W-1:0] sum_q;
    logic [LAT-1:1][W-1:0] carry_q;
    logic [N-1:0]          a_pipe [1:N-2];
    logic [N-1:2]          b_tap;

    // Delay operand a so that it meets every accumulation row.
    always_ff @(posedge clk) begin
        a_pipe[1] <= a;
        for (int k = 2; k <= N - 2; k++) begin
            a_pipe[k] <= a_pipe[k-1];
        end
    end

    // Delay each multiplier bit j by j-1 registers to reach row j.
    generate
        for (genvar j = 2; j < N; j++) begin : g_bdly
            logic [j-2:0] line_q;
            if (j == 2) begin : g_one
                always_ff @(posedge clk) line_q <= b[j];
            end else begin : g_many
                always_ff @(posedge clk) line_q <= {line_q[j-3:0], b[j]};
            end
            assign b_tap[j] = line_q[j-2];
        end
    endgenerate

    mult_seed_row #(.N(N)) u_seed (
        .clk     (clk),
        .a_i     (a),
        .b_lo_i  (b[1:0]),
        .sum_o   (sum_q[1]),
        .carry_o (carry_q[1])
    );

    generate
        for (genvar k = 2; k <= N - 1; k++) begin : g_fold
            mult_fold_row #(.N(N), .K(k)) u_fold (
                .clk     (clk),
                .a_i     (a_pipe[k-1]),
                .b_bit_i (b_tap[k]),
                .sum_i   (sum_q[k-1]),
                .carry_i (carry_q[k-1]),
                .sum_o   (sum_q[k]),
                .carry_o (carry_q[k])
            );
        end
        for (genvar t = 1; t <= N - 1; t++) begin : g_resolve
            mult_resolve_row #(.N(N), .T(t)) u_res (
                .clk     (clk),
                .sum_i   (sum_q[N+t-2]),
                .carry_i (carry_q[N+t-2]),
                .sum_o   (sum_q[N+t-1]),
                .carry_o (carry_q[N+t-1])
            );
        end
    endgenerate

    // Last stage: only the top bit can still hold a carry; merge and register.
    always_ff @(posedge clk) begin
        p <= {sum_q[LAT-1][W-1] ^ carry_q[LAT-1][W-1],
              sum_q[LAT-1][W-2:0] | carry_q[LAT-1][W-2:0]};
    end

    mult_valid_line #(.DEPTH(LAT)) u_vline (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (in_valid),
        .flag_o (out_valid)
    );

endmodule

// File: rtl/lut_pipe_mult_checker.sv
`timescale 1ns/1ps
// Module: assertion checker for lut_pipe_mult, attached with bind. It keeps
// its own delayed copies of the operands and the flag, and compares them with
// the outputs. It also watches the top column of every internal stage.
module lut_pipe_mult_checker #(
    parameter int N = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            in_valid,
    input logic [N-1:0]                    a,
    input logic [N-1:0]                    b,
    input logic                            out_valid,
    input logic [2*N-1:0]                  p,
    input logic [2*N-2:1][2*N-1:0]         stage_sum,
    input logic [2*N-2:1][2*N-1:0]         stage_carry
);
    localparam int W   = 2 * N;
    localparam int LAT = 2 * N - 1;

    logic [LAT-1:0][N-1:0] ref_a;
    logic [LAT-1:0][N-1:0] ref_b;
    logic [LAT-1:0]        ref_v;
    int unsigned           fill_cnt;
    logic                  top_clash;

    // Independent delay lines of operands and flag for comparison.
    always_ff @(posedge clk) begin
        ref_a <= {ref_a[LAT-2:0], a};
        ref_b <= {ref_b[LAT-2:0], b};
        if (!rst_n) ref_v <= '0;
        else        ref_v <= {ref_v[LAT-2:0], in_valid};
    end

    // Count edges since reset release, saturating at the latency.
    always_ff @(posedge clk) begin
        if (!rst_n)              fill_cnt <= 0;
        else if (fill_cnt < LAT) fill_cnt <= fill_cnt + 1;
    end

    // Flag any stage whose top column holds both a sum and a carry.
    always_comb begin
        top_clash = 1'b0;
        for (int s = 1; s <= LAT - 1; s++) begin
            top_clash = top_clash | (stage_sum[s][W-1] & stage_carry[s][W-1]);
        end
    end

    p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (p == (W'(ref_a[LAT-1]) * W'(ref_b[LAT-1]))));

    p_valid_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == ref_v[LAT-1]);

    p_no_top_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt >= LAT) |-> (!top_clash && !$isunknown({stage_sum, stage_carry})));

    p_fill_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt < LAT) |-> !out_valid);

endmodule

bind lut_pipe_mult lut_pipe_mult_checker #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .a           (a),
    .b           (b),
    .out_valid   (out_valid),
    .p           (p),
    .stage_sum   (sum_q),
    .stage_carry (carry_q)
);

// File: tb/tb_lut_pipe_mult.sv
`timescale 1ns/1ps
// Bench: drives lut_pipe_mult with corner and seeded random operand pairs,
// and compares every output cycle with a product computed in the bench.
module tb_lut_pipe_mult;
    localparam int N   = 8;
    localparam int W   = 2 * N;
    localparam int LAT = 2 * N - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic         out_valid;
    logic [W-1:0] p;

    int n_cmp = 0;
    int n_bad = 0;
    int edge_no = 0;
    int last_rst = 0;
    bit done = 1'b0;

    logic         hv [0:4095];
    logic [N-1:0] ha [0:4095];
    logic [N-1:0] hb [0:4095];

    always #4 clk = ~clk;

    lut_pipe_mult #(.N(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .p         (p)
    );

    function automatic logic [W-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        return W'(x) * W'(y);
    endfunction

    task automatic report(input string tag, input bit ok, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at edge %0d: got %h expected %h", tag, edge_no, got, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then check the outputs one
    // falling edge later, against the pair sampled LAT-1 edges earlier.
    task automatic tick(input bit r, input bit v, input logic [N-1:0] x, input logic [N-1:0] y, input string tag);
        int  idx;
        bit  exp_v;
        rst_n = r; in_valid = v; a = x; b = y;
        hv[edge_no+1] = v; ha[edge_no+1] = x; hb[edge_no+1] = y;
        if (!r) last_rst = edge_no + 1;
        @(posedge clk);
        edge_no++;
        @(negedge clk);
        idx   = edge_no - LAT + 1;
        exp_v = 1'b0;
        if (idx >= 1 && idx > last_rst) exp_v = hv[idx];
        report(tag, out_valid == exp_v, W'(out_valid), W'(exp_v));
        if (exp_v) report(tag, p == ref_mul(ha[idx], hb[idx]), p, ref_mul(ha[idx], hb[idx]));
    endtask

    function automatic logic [N-1:0] corner(input int i, input bit second);
        logic [N-1:0] ones = '1;
        logic [N-1:0] alt  = {(N/2){2'b10}};
        case (i)
            0:  return second ? '0 : '0;
            1:  return second ? ones : '0;
            2:  return second ? '0 : ones;
            3:  return second ? ones : N'(1);
            4:  return second ? N'(1) : ones;
            5:  return ones;
            6:  return second ? ~alt : alt;
            7:  return second ? alt : ~alt;
            8:  return alt;
            9:  return N'(1) << (N - 1);
            10: return second ? (ones - N'(1)) : ones;
            default: return N'(1);
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        // R5: valid requests during reset are dropped.
        repeat (4) tick(1'b0, 1'b1, N'($urandom), N'($urandom), "R5");
        // R5: the fill window after release stays silent.
        repeat (LAT + 2) tick(1'b1, 1'b1, N'($urandom), N'($urandom), "R5");
        // R1 and R4: directed corner pairs, back to back; all-ones repeated.
        for (int i = 0; i < 12; i++) begin
            tick(1'b1, 1'b1, corner(i, 1'b0), corner(i, 1'b1), (i == 5) ? "R4" : "R1");
        end
        repeat (4) tick(1'b1, 1'b1, '1, '1, "R4");
        // R3: long random stream, one pair every cycle.
        repeat (800) tick(1'b1, 1'b1, N'($urandom), N'($urandom), "R3");
        // R2: random gaps in the request flag.
        repeat (400) tick(1'b1, 1'($urandom), N'($urandom), N'($urandom), "R2");
        // R5: reset in mid-stream discards requests that are in flight.
        repeat (10) tick(1'b1, 1'b1, N'($urandom), N'($urandom), "R5");
        repeat (2) tick(1'b0, 1'b1, N'($urandom), N'($urandom), "R5");
        repeat (LAT + 5) tick(1'b1, 1'b1, N'($urandom), N'($urandom), "R5");
        // R2: drain with no requests.
        repeat (LAT + 2) tick(1'b1, 1'b0, '0, '0, "R2");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R3 watchdog: got no end of run expected end before timeout");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule